// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge Sequencer

This block sits between a processor's interrupt acknowledge strobe and two chained priority resolvers: a primary resolver and a secondary resolver. The secondary resolver's output reaches the processor only through one input of the primary resolver, the cascade input. Each resolver reports a winning line number and a valid flag. The resolvers and the programming of their base registers are outside this block.

While the secondary resolver holds a winning request, the block produces a toggling cascade request. The primary resolver uses its edges to latch its cascade input. When the processor pulses the acknowledge strobe, the block decides which resolvers to acknowledge. One cycle later it returns the acknowledge strobes, the acknowledged line numbers and an 8-bit vector with a one-cycle valid flag. The vector combines the upper five bits of the chosen resolver's base with the 3-bit line number. If no request survives at acknowledge time, the block substitutes line 7 of the resolver concerned, which gives a spurious vector.

After each acknowledge, the interrupt request to the processor is held off for a settle window of SETTLE_CYCLES cycles, so that both resolvers can re-evaluate before the request is asserted again.

Top module: `cascade_ack_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, the block drives low `vec_valid`, `pri_ack`, `sec_ack`, `cascade_req` and both ack line outputs. `int_req` is then equal to `pri_valid`.
- R2: If `sec_valid` is high and `cascade_req` is low, `cascade_req` is high in the next cycle. A high `cascade_req` is always low in the next cycle. If `sec_valid` is low, `cascade_req` is low in the next cycle.
- R3: If `pri_valid` is high and `pri_line` is not 2, an acknowledge gives `pri_ack`=1 with `pri_ack_line`=`pri_line` and `sec_ack`=0. The vector is then {`pri_base`[7:3], `pri_line`}.
- R4: If `pri_valid` is high, `pri_line`=2 and `sec_valid` is high, an acknowledge gives `pri_ack`=1 with line 2 and `sec_ack`=1 with `sec_ack_line`=`sec_line`. The vector is then {`sec_base`[7:3], `sec_line`}.
- R5: If `pri_valid` is high, `pri_line`=2 and `sec_valid` is low, an acknowledge gives `pri_ack`=1 with line 2 and `sec_ack`=0. The vector is then {`sec_base`[7:3], 3'd7}.
- R6: If `pri_valid` is low at acknowledge time, no resolver is acknowledged. Both ack lines read 0 and the vector is {`pri_base`[7:3], 3'd7}.
- R7: Bits [2:0] of `pri_base` and `sec_base` have no effect on the vector.
- R8: The vector, the ack strobes and the ack lines appear in the cycle after the cycle in which `ack_strobe` is sampled high. `vec_valid` is high for exactly that one cycle. Without a strobe, `vec_valid`, `pri_ack` and `sec_ack` stay low.
- R9: In the SETTLE_CYCLES cycles that follow an acknowledge edge, `int_req` is low. After that window `int_req` follows `pri_valid` again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ack_strobe | input | 1 | Processor interrupt acknowledge, one cycle |
| pri_valid | input | 1 | Primary resolver has a winning request |
| pri_line | input | 3 | Primary resolver winning line |
| sec_valid | input | 1 | Secondary resolver has a winning request |
| sec_line | input | 3 | Secondary resolver winning line |
| pri_base | input | 8 | Primary vector base (bits 7:3 used) |
| sec_base | input | 8 | Secondary vector base (bits 7:3 used) |
| int_req | output | 1 | Interrupt request to the processor |
| cascade_req | output | 1 | Toggling request into primary line 2 |
| pri_ack | output | 1 | Acknowledge strobe to primary resolver |
| pri_ack_line | output | 3 | Line acknowledged on primary |
| sec_ack | output | 1 | Acknowledge strobe to secondary resolver |
| sec_ack_line | output | 3 | Line acknowledged on secondary |
| vector | output | 8 | Returned interrupt vector |
| vec_valid | output | 1 | One-cycle qualifier for `vector` |

## Verification
The hardest case to reach is the one where the primary resolver wins on its cascade line but the secondary resolver has already withdrawn its request by acknowledge time. In a real system this happens only through a race. The bench creates it directly: it drives `pri_line`=2 with `sec_valid` low in the same cycle as the strobe. It also checks that the secondary resolver receives no acknowledge and that the returned vector uses the secondary base. Base bytes with nonzero low bits are mixed into the vector table, so that any leak of those bits into the vector is detected.

// File: rtl/cascade_ack_pkg.sv
package cascade_ack_pkg;
    localparam int LINE_W = 3;
    localparam int VEC_W  = 8;
    localparam logic [LINE_W-1:0] CASCADE_LINE  = LINE_W'(2);
    localparam logic [LINE_W-1:0] SPURIOUS_LINE = {LINE_W{1'b1}};

    typedef struct packed {
        logic              pri_ack;
        logic [LINE_W-1:0] pri_line;
        logic              sec_ack;
        logic [LINE_W-1:0] sec_line;
        logic [VEC_W-1:0]  vector;
    } ack_result_t;

    // Upper bits come from the base; the line number fills the low bits.
    function automatic logic [VEC_W-1:0] form_vector(input logic [VEC_W-1:0] base,
                                                     input logic [LINE_W-1:0] line);
        return {base[VEC_W-1:LINE_W], line};
    endfunction
endpackage

// File: rtl/cascade_ack_decide.sv
module cascade_ack_decide
    import cascade_ack_pkg::*;
(
    input  logic              pri_valid,
    input  logic [LINE_W-1:0] pri_line,
    input  logic              sec_valid,
    input  logic [LINE_W-1:0] sec_line,
    input  logic [VEC_W-1:0]  pri_base,
    input  logic [VEC_W-1:0]  sec_base,
    output ack_result_t       result
);
    always_comb begin
        result = '0;
        if (!pri_valid) begin
            result.vector = form_vector(pri_base, SPURIOUS_LINE);
        end else if (pri_line != CASCADE_LINE) begin
            result.pri_ack  = 1'b1;
            result.pri_line = pri_line;
            result.vector   = form_vector(pri_base, pri_line);
        end else begin
            result.pri_ack  = 1'b1;
            result.pri_line = CASCADE_LINE;
            if (sec_valid) begin
                result.sec_ack  = 1'b1;
                result.sec_line = sec_line;
                result.vector   = form_vector(sec_base, sec_line);
            end else begin
                result.vector   = form_vector(sec_base, SPURIOUS_LINE);
            end
        end
    end
endmodule

// File: rtl/cascade_pulser.sv
module cascade_pulser (
    input  logic clk,
    input  logic rst,
    input  logic sec_valid,
    output logic cascade_req
);
    always_ff @(posedge clk) begin
        if (rst) cascade_req <= 1'b0;
        else     cascade_req <= sec_valid & ~cascade_req;
    end

    p_cascade_falls_r2: assert property (@(posedge clk) disable iff (rst)
        cascade_req |=> !cascade_req);
    p_cascade_idle_r2: assert property (@(posedge clk) disable iff (rst)
        !sec_valid |=> !cascade_req);
endmodule

// File: rtl/settle_timer.sv
module settle_timer #(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic busy
);
    localparam int CNT_W = $clog2(SETTLE_CYCLES + 1);
    localparam logic [CNT_W-1:0] LOAD = CNT_W'(SETTLE_CYCLES);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (start)       cnt <= LOAD;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    p_cnt_bound_r9: assert property (@(posedge clk) disable iff (rst)
        cnt <= LOAD);
    p_start_loads_r9: assert property (@(posedge clk) disable iff (rst)
        start |=> busy);
endmodule

// File: rtl/cascade_ack_seq.sv
module cascade_ack_seq
    import cascade_ack_pkg::*;
#(
    parameter int SETTLE_CYCLES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       ack_strobe,
    input  logic       pri_valid,
    input  logic [2:0] pri_line,
    input  logic       sec_valid,
    input  logic [2:0] sec_line,
    input  logic [7:0] pri_base,
    input  logic [7:0] sec_base,
    output logic       int_req,
    output logic       cascade_req,
    output logic       pri_ack,
    output logic [2:0] pri_ack_line,
    output logic       sec_ack,
    output logic [2:0] sec_ack_line,
    output logic [7:0] vector,
    output logic       vec_valid
);
    ack_result_t decided;
    ack_result_t held;
    logic        settling;

    cascade_ack_decide u_decide (
        .pri_valid (pri_valid),
        .pri_line  (pri_line),
        .sec_valid (sec_valid),
        .sec_line  (sec_line),
        .pri_base  (pri_base),
        .sec_base  (sec_base),
        .result    (decided)
    );

    cascade_pulser u_pulser (
        .clk         (clk),
        .rst         (rst),
        .sec_valid   (sec_valid),
        .cascade_req (cascade_req)
    );

    settle_timer #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk   (clk),
        .rst   (rst),
        .start (ack_strobe),
        .busy  (settling)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            held      <= '0;
            vec_valid <= 1'b0;
        end else begin
            vec_valid <= ack_strobe;
            held      <= ack_strobe ? decided : '0;
        end
    end

    assign pri_ack      = held.pri_ack;
    assign pri_ack_line = held.pri_line;
    assign sec_ack      = held.sec_ack;
    assign sec_ack_line = held.sec_line;
    assign vector       = held.vector;
    assign int_req      = pri_valid & ~settling;

    p_valid_follows_strobe_r8: assert property (@(posedge clk) disable iff (rst)
        vec_valid |-> $past(ack_strobe));
    p_sec_needs_cascade_r4: assert property (@(posedge clk) disable iff (rst)
        sec_ack |-> (pri_ack && pri_ack_line == CASCADE_LINE));
    p_spurious_line_r6: assert property (@(posedge clk) disable iff (rst)
        (vec_valid && !pri_ack) |-> (vector[2:0] == SPURIOUS_LINE));
    p_no_req_after_ack_r9: assert property (@(posedge clk) disable iff (rst)
        ack_strobe |=> !int_req);
    p_ack_qualified_r8: assert property (@(posedge clk) disable iff (rst)
        (pri_ack || sec_ack) |-> vec_valid);
endmodule

// File: tb/cascade_ack_seq_tb.sv
module cascade_ack_seq_tb_top;
    logic clk = 1'b0;
    logic rst, ack_strobe, pri_valid, sec_valid;
    logic [2:0] pri_line, sec_line;
    logic [7:0] pri_base, sec_base;
    logic int_req, cascade_req, pri_ack, sec_ack, vec_valid;
    logic [2:0] pri_ack_line, sec_ack_line;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cascade_ack_seq #(.SETTLE_CYCLES(2)) dut_i (
        .clk(clk), .rst(rst), .ack_strobe(ack_strobe),
        .pri_valid(pri_valid), .pri_line(pri_line),
        .sec_valid(sec_valid), .sec_line(sec_line),
        .pri_base(pri_base), .sec_base(sec_base),
        .int_req(int_req), .cascade_req(cascade_req),
        .pri_ack(pri_ack), .pri_ack_line(pri_ack_line),
        .sec_ack(sec_ack), .sec_ack_line(sec_ack_line),
        .vector(vector), .vec_valid(vec_valid)
    );

    // {pv, pl, sv, sl, pbase, sbase, exp_vec, exp_pack, exp_pline, exp_sack, exp_sline}
    localparam int NV = 8;
    localparam logic [39:0] TBL [NV] = '{
        {1'b1, 3'd3, 1'b0, 3'd0, 8'h08, 8'h70, 8'h0B, 1'b1, 3'd3, 1'b0, 3'd0}, // R3
        {1'b1, 3'd0, 1'b1, 3'd5, 8'h20, 8'h28, 8'h20, 1'b1, 3'd0, 1'b0, 3'd0}, // R3
        {1'b1, 3'd2, 1'b1, 3'd5, 8'h08, 8'h70, 8'h75, 1'b1, 3'd2, 1'b1, 3'd5}, // R4
        {1'b1, 3'd2, 1'b0, 3'd0, 8'h08, 8'h70, 8'h77, 1'b1, 3'd2, 1'b0, 3'd0}, // R5
        {1'b0, 3'd4, 1'b1, 3'd4, 8'h08, 8'h70, 8'h0F, 1'b0, 3'd0, 1'b0, 3'd0}, // R6
        {1'b1, 3'd6, 1'b0, 3'd0, 8'h0F, 8'h77, 8'h0E, 1'b1, 3'd6, 1'b0, 3'd0}, // R7
        {1'b1, 3'd2, 1'b1, 3'd0, 8'hFF, 8'hA5, 8'hA0, 1'b1, 3'd2, 1'b1, 3'd0}, // R7
        {1'b0, 3'd0, 1'b0, 3'd0, 8'hC3, 8'h00, 8'hC7, 1'b0, 3'd0, 1'b0, 3'd0}  // R6 R7
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_in(input logic pv, input logic [2:0] pl, input logic sv,
                          input logic [2:0] sl, input logic [7:0] pb, input logic [7:0] sb);
        pri_valid = pv; pri_line = pl; sec_valid = sv; sec_line = sl;
        pri_base = pb; sec_base = sb;
    endtask

    initial begin
        #(5 * 200000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ack_strobe = 1'b0;
        set_in(1'b0, 3'd0, 1'b0, 3'd0, 8'h00, 8'h00);
        repeat (3) @(negedge clk);
        chk("R1 vec_valid", vec_valid, 0);
        chk("R1 acks", {pri_ack, sec_ack, pri_ack_line, sec_ack_line}, 0);
        chk("R1 cascade", cascade_req, 0);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 after reset", {vec_valid, pri_ack, sec_ack, cascade_req}, 0);

        // Table-driven acknowledge cases: R3 R4 R5 R6 R7 R8
        for (int i = 0; i < NV; i++) begin
            set_in(TBL[i][39], TBL[i][38:36], TBL[i][35], TBL[i][34:32],
                   TBL[i][31:24], TBL[i][23:16]);
            ack_strobe = 1'b1;
            @(negedge clk);
            ack_strobe = 1'b0;
            chk($sformatf("R8 valid row %0d", i), vec_valid, 1);
            chk($sformatf("R3-7 vector row %0d", i), vector, TBL[i][15:8]);
            chk($sformatf("R3 pri_ack row %0d", i), {pri_ack, pri_ack_line}, TBL[i][7:4]);
            chk($sformatf("R4 sec_ack row %0d", i), {sec_ack, sec_ack_line}, TBL[i][3:0]);
            @(negedge clk);
            chk($sformatf("R8 single pulse row %0d", i), {vec_valid, pri_ack, sec_ack}, 0);
            repeat (2) @(negedge clk);
        end

        // R8: no strobe, no acknowledge
        set_in(1'b1, 3'd2, 1'b1, 3'd1, 8'h08, 8'h70);
        repeat (3) begin
            @(negedge clk);
            chk("R8 idle without strobe", {vec_valid, pri_ack, sec_ack}, 0);
        end

        // R2: cascade toggling with secondary request
        set_in(1'b0, 3'd0, 1'b0, 3'd0, 8'h08, 8'h70);
        repeat (2) @(negedge clk);
        chk("R2 cascade idle", cascade_req, 0);
        sec_valid = 1'b1;
        @(negedge clk); chk("R2 cascade rise", cascade_req, 1);
        @(negedge clk); chk("R2 cascade fall", cascade_req, 0);
        @(negedge clk); chk("R2 cascade rise again", cascade_req, 1);
        sec_valid = 1'b0;
        @(negedge clk); chk("R2 cascade drop", cascade_req, 0);
        @(negedge clk); chk("R2 cascade stays low", cascade_req, 0);

        // R9: settle window after acknowledge
        set_in(1'b1, 3'd1, 1'b0, 3'd0, 8'h08, 8'h70);
        #1 chk("R9 int_req before ack", int_req, 1);
        @(negedge clk);
        ack_strobe = 1'b1;
        @(negedge clk);
        ack_strobe = 1'b0;
        chk("R9 held low 1", int_req, 0);
        @(negedge clk); chk("R9 held low 2", int_req, 0);
        @(negedge clk); chk("R9 released", int_req, 1);
        pri_valid = 1'b0;
        #1 chk("R9 follows pri_valid", int_req, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule